// File: doc/BRIEF.md
# Execution and Context Synchronization Controller

This block sits between instruction dispatch and an in-order completion tracker. For each dispatched instruction it decides whether the instruction may issue now. For each completion report it decides whether the completion may be accepted. Both decisions depend on the instruction's synchronization class. Every issued instruction receives a tag and the privilege context it runs under. The block flags a privileged instruction that issues while the effective context is user mode.

Two privilege registers are kept. The architectural register follows writes to the machine-state register. The effective register is the context actually handed to newly issued instructions. It takes the architectural value only when an instruction-synchronize, a system call or a return-from-interrupt completes. A state-register write that is not followed by an instruction-synchronize therefore leaves younger instructions in the old context.

Dispatch is a valid/ready stream. The `disp_ready` output is a combinational function of the current state and of the `disp_class` offered with `disp_valid`. An instruction issues in the cycle in which both `disp_valid` and `disp_ready` are high. The issue outputs (`iss_tag`, `iss_user`, `iss_violation`) are meaningful in that cycle only. The payload must stay stable while the source waits. Completion is also valid/ready. A report is consumed when `cmp_valid` and `cmp_ready` are both high. Reports may arrive in any order among ordinary instructions.

Top module: `exsync_ctrl`

## Requirements
- R1: After reset, both privilege outputs read 0 (supervisor), `busy_count` reads 0, and a plain instruction (class 0) sees `disp_ready` high.
- R2: Class 0 (plain) instructions issue back to back. Their tags count up from 0 and wrap modulo 16. `busy_count` follows issues minus accepted completions. `disp_ready` is low while 15 instructions are outstanding.
- R3: The issue-waiting classes are 1 (execution sync), 2 (state-register write), 5 (system call), 6 (return from interrupt) and 7. They see `disp_ready` low while `busy_count` is nonzero.
- R4: After an instruction of any class other than 0 issues, `disp_ready` stays low for every class until that instruction's completion is accepted.
- R5: Class 3 (memory sync) and class 4 (instruction sync) may issue while older instructions are outstanding. A completion report for either class sees `cmp_ready` low until that instruction is the only one outstanding.
- R6: Completion of class 2 loads `disp_new_priv` (1 = user) into `arch_user` and leaves `eff_user` unchanged. Younger instructions still get the old `iss_user`, and a privileged one is not flagged.
- R7: Completion of class 4 copies `arch_user` into `eff_user`.
- R8: Completion of class 5 clears both privilege outputs to supervisor. Completion of class 6 loads its `disp_new_priv` into both.
- R9: `iss_user` equals `eff_user` at issue. `iss_violation` is high exactly when `disp_privileged` is high and `eff_user` is 1.
- R10: A completion report whose tag is not outstanding is accepted with no effect: `busy_count` is unchanged.
- R11: `disp_ready` is low while the next tag to be allocated is still outstanding, even below the 15-instruction limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offers an instruction |
| disp_ready | output | 1 | Block accepts the offered instruction this cycle |
| disp_class | input | 3 | Synchronization class, encoded as in R2 to R8 |
| disp_new_priv | input | 1 | New privilege for class 2 and class 6 (1 = user) |
| disp_privileged | input | 1 | Offered instruction is supervisor-only |
| iss_tag | output | 4 | Tag given to the issuing instruction |
| iss_user | output | 1 | Context tag of the issuing instruction (1 = user) |
| iss_violation | output | 1 | Issuing instruction is a privilege violation |
| cmp_valid | input | 1 | Completion report present |
| cmp_ready | output | 1 | Completion report accepted this cycle |
| cmp_tag | input | 4 | Tag of the completing instruction |
| arch_user | output | 1 | Architectural privilege (1 = user) |
| eff_user | output | 1 | Effective context for new issues (1 = user) |
| busy_count | output | 4 | Issued but uncompleted instructions |

## Verification
A corrupted outstanding count or tag table shows up at `disp_ready` on the next offer. A synchronizing instruction then issues with older work still pending, or it stalls forever, and the count read after the completions no longer returns to zero. A barrier that is held or released wrongly shows up as a younger instruction issuing, or failing to issue, in the same cycle it is offered. A mis-timed context update appears on `iss_user` and `iss_violation` of the very next issued instruction. The directed sequences therefore probe ready and the issue tags one cycle after each completion.

// File: rtl/exsync_pkg.sv
package exsync_pkg;

  typedef enum logic [2:0] {
    SC_PLAIN   = 3'd0,
    SC_EXEC    = 3'd1,
    SC_MSRW    = 3'd2,
    SC_MSYNC   = 3'd3,
    SC_ISYNC   = 3'd4,
    SC_SYSCALL = 3'd5,
    SC_RFI     = 3'd6,
    SC_RSVD    = 3'd7
  } sync_class_e;

  // classes that need every older instruction finished before they issue
  function automatic logic waits_at_issue(input logic [2:0] c);
    return (c == SC_EXEC) || (c == SC_MSRW) || (c == SC_SYSCALL) ||
           (c == SC_RFI) || (c == SC_RSVD);
  endfunction

  // classes that may issue early but must be alone when they complete
  function automatic logic waits_at_complete(input logic [2:0] c);
    return (c == SC_MSYNC) || (c == SC_ISYNC);
  endfunction

  // classes whose completion refreshes the effective context
  function automatic logic refreshes_ctx(input logic [2:0] c);
    return (c == SC_ISYNC) || (c == SC_SYSCALL) || (c == SC_RFI);
  endfunction

endpackage

// File: rtl/exsync_tag_table.sv
module exsync_tag_table
  import exsync_pkg::*;
#(
  parameter int TAGW = 4,
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc,
  input  logic [2:0]      alloc_cls,
  input  logic            alloc_np,
  input  logic            cmp_valid,
  input  logic [TAGW-1:0] cmp_tag,
  output logic [TAGW-1:0] next_tag,
  output logic            next_busy,
  output logic [CNTW-1:0] cnt,
  output logic            cmp_ready,
  output logic            cmp_fire,
  output logic [2:0]      cmp_cls,
  output logic            cmp_np
);
  localparam int DEPTH  = 1 << TAGW;
  localparam int MAXOUT = (1 << CNTW) - 1;

  logic [DEPTH-1:0] busy_q;
  logic [2:0]       cls_q [DEPTH];
  logic             np_q  [DEPTH];
  logic             hit_busy;

  assign hit_busy  = busy_q[cmp_tag];
  assign cmp_cls   = cls_q[cmp_tag];
  assign cmp_np    = np_q[cmp_tag];
  assign next_busy = busy_q[next_tag];

  // memory/instruction sync may only retire as the sole outstanding entry
  assign cmp_ready = !(hit_busy && waits_at_complete(cmp_cls)) ||
                     (cnt == CNTW'(1));
  assign cmp_fire  = cmp_valid && cmp_ready && hit_busy;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[i] <= 1'b0;
        cls_q[i]  <= 3'd0;
        np_q[i]   <= 1'b0;
      end else if (alloc && (next_tag == TAGW'(i))) begin
        busy_q[i] <= 1'b1;
        cls_q[i]  <= alloc_cls;
        np_q[i]   <= alloc_np;
      end else if (cmp_fire && (cmp_tag == TAGW'(i))) begin
        busy_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_tag <= '0;
      cnt      <= '0;
    end else begin
      if (alloc) next_tag <= next_tag + TAGW'(1);
      if (alloc && !cmp_fire)      cnt <= cnt + CNTW'(1);
      else if (!alloc && cmp_fire) cnt <= cnt - CNTW'(1);
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (cnt != CNTW'(MAXOUT)));

  a_r11_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !busy_q[next_tag]);

  a_r10_ghost_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !hit_busy && !alloc) |=> $stable(cnt));

endmodule

// File: rtl/exsync_issue_gate.sv
module exsync_issue_gate
  import exsync_pkg::*;
#(
  parameter int TAGW = 4,
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_valid,
  input  logic [2:0]      disp_cls,
  input  logic [CNTW-1:0] cnt,
  input  logic            next_busy,
  input  logic [TAGW-1:0] next_tag,
  input  logic            cmp_fire,
  input  logic [TAGW-1:0] cmp_tag,
  output logic            disp_ready,
  output logic            iss_fire,
  output logic            bar_active
);
  localparam int MAXOUT = (1 << CNTW) - 1;

  logic            bar_q;
  logic [TAGW-1:0] bar_tag_q;
  logic            room;

  assign room       = !next_busy && (cnt != CNTW'(MAXOUT));
  assign disp_ready = !bar_q && room &&
                      (!waits_at_issue(disp_cls) || (cnt == '0));
  assign iss_fire   = disp_valid && disp_ready;
  assign bar_active = bar_q;

  // any synchronizing class holds younger work until it retires
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_q     <= 1'b0;
      bar_tag_q <= '0;
    end else if (iss_fire && (disp_cls != SC_PLAIN)) begin
      bar_q     <= 1'b1;
      bar_tag_q <= next_tag;
    end else if (bar_q && cmp_fire && (cmp_tag == bar_tag_q)) begin
      bar_q <= 1'b0;
    end
  end

  a_r4_barrier_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_q && !cmp_fire) |=> bar_q);

endmodule

// File: rtl/exsync_ctx_regs.sv
module exsync_ctx_regs
  import exsync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_fire,
  input  logic [2:0] cmp_cls,
  input  logic       cmp_np,
  output logic       arch_user,
  output logic       eff_user
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arch_user <= 1'b0;
      eff_user  <= 1'b0;
    end else if (cmp_fire) begin
      case (cmp_cls)
        SC_MSRW:    arch_user <= cmp_np;
        SC_ISYNC:   eff_user  <= arch_user;
        SC_SYSCALL: begin
          arch_user <= 1'b0;
          eff_user  <= 1'b0;
        end
        SC_RFI: begin
          arch_user <= cmp_np;
          eff_user  <= cmp_np;
        end
        default: ;
      endcase
    end
  end

  a_r7_eff_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(eff_user) |-> $past(cmp_fire && refreshes_ctx(cmp_cls)));

  a_r6_msrw_keeps_eff: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && (cmp_cls == SC_MSRW)) |=> $stable(eff_user));

endmodule

// File: rtl/exsync_ctrl.sv
module exsync_ctrl
  import exsync_pkg::*;
#(
  parameter int TAGW = 4,
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_valid,
  output logic            disp_ready,
  input  logic [2:0]      disp_class,
  input  logic            disp_new_priv,
  input  logic            disp_privileged,
  output logic [TAGW-1:0] iss_tag,
  output logic            iss_user,
  output logic            iss_violation,
  input  logic            cmp_valid,
  output logic            cmp_ready,
  input  logic [TAGW-1:0] cmp_tag,
  output logic            arch_user,
  output logic            eff_user,
  output logic [CNTW-1:0] busy_count
);
  logic            iss_fire, next_busy, cmp_fire, cmp_np, bar_active;
  logic [2:0]      cmp_cls;
  logic [TAGW-1:0] next_tag;
  logic [CNTW-1:0] cnt;

  exsync_tag_table #(.TAGW(TAGW), .CNTW(CNTW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .alloc(iss_fire), .alloc_cls(disp_class), .alloc_np(disp_new_priv),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .next_tag(next_tag), .next_busy(next_busy), .cnt(cnt),
    .cmp_ready(cmp_ready), .cmp_fire(cmp_fire),
    .cmp_cls(cmp_cls), .cmp_np(cmp_np)
  );

  exsync_issue_gate #(.TAGW(TAGW), .CNTW(CNTW)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_cls(disp_class),
    .cnt(cnt), .next_busy(next_busy), .next_tag(next_tag),
    .cmp_fire(cmp_fire), .cmp_tag(cmp_tag),
    .disp_ready(disp_ready), .iss_fire(iss_fire), .bar_active(bar_active)
  );

  exsync_ctx_regs u_ctx (
    .clk(clk), .rst_n(rst_n),
    .cmp_fire(cmp_fire), .cmp_cls(cmp_cls), .cmp_np(cmp_np),
    .arch_user(arch_user), .eff_user(eff_user)
  );

  assign iss_tag       = next_tag;
  assign iss_user      = eff_user;
  assign iss_violation = disp_privileged && eff_user;
  assign busy_count    = cnt;

  a_r3_issue_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_fire && waits_at_issue(disp_class)) |=> (cnt == CNTW'(1)));

  a_r5_sync_last: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && waits_at_complete(cmp_cls)) |=> (cnt == '0));

  a_r4_no_issue_behind: assert property (@(posedge clk) disable iff (!rst_n)
    bar_active |-> !iss_fire);

endmodule

// File: tb/sim_exsync_ctrl.sv
module sim_exsync_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_valid = 1'b0, disp_new_priv = 1'b0, disp_privileged = 1'b0;
  logic [2:0] disp_class = 3'd0;
  logic       cmp_valid = 1'b0;
  logic [3:0] cmp_tag = 4'd0;
  logic       disp_ready, iss_user, iss_violation, cmp_ready, arch_user, eff_user;
  logic [3:0] iss_tag, busy_count;

  int   nchk = 0, nerr = 0;
  bit   done = 0;
  logic [3:0] exp_tag = 4'd0;

  always #10 clk = ~clk;

  exsync_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_class(disp_class), .disp_new_priv(disp_new_priv),
    .disp_privileged(disp_privileged), .iss_tag(iss_tag), .iss_user(iss_user),
    .iss_violation(iss_violation), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
    .cmp_tag(cmp_tag), .arch_user(arch_user), .eff_user(eff_user),
    .busy_count(busy_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input bit np, input bit pr,
                       output logic [3:0] tag, output bit u, output bit v);
    int w = 0;
    disp_valid = 1'b1; disp_class = c; disp_new_priv = np; disp_privileged = pr;
    #1;
    while (!disp_ready && w < 50) begin
      @(negedge clk); #1; w++;
    end
    chk(disp_ready, "R2", "issue accepted", int'(disp_ready), 1);
    tag = iss_tag; u = iss_user; v = iss_violation;
    chk(tag == exp_tag, "R2", "issue tag", int'(tag), int'(exp_tag));
    exp_tag = exp_tag + 4'd1;
    @(posedge clk);
    @(negedge clk);
    disp_valid = 1'b0; disp_privileged = 1'b0;
  endtask

  task automatic complete(input logic [3:0] t);
    int w = 0;
    cmp_valid = 1'b1; cmp_tag = t;
    #1;
    while (!cmp_ready && w < 50) begin
      @(negedge clk); #1; w++;
    end
    @(posedge clk);
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic probe_ready(input logic [2:0] c, output bit r);
    disp_valid = 1'b1; disp_class = c;
    #1 r = disp_ready;
    disp_valid = 1'b0;
  endtask

  task automatic probe_cmp(input logic [3:0] t, output bit r);
    cmp_valid = 1'b1; cmp_tag = t;
    #1 r = cmp_ready;
    cmp_valid = 1'b0;
  endtask

  task automatic t_reset();
    bit r;
    probe_ready(3'd0, r);
    chk(r, "R1", "ready after reset", int'(r), 1);
    chk(arch_user == 0 && eff_user == 0, "R1", "supervisor after reset",
        int'({arch_user, eff_user}), 0);
    chk(busy_count == 0, "R1", "count after reset", int'(busy_count), 0);
  endtask

  task automatic t_plain();
    logic [3:0] a, b, c; bit u, v;
    issue(3'd0, 0, 0, a, u, v);
    issue(3'd0, 0, 0, b, u, v);
    issue(3'd0, 0, 0, c, u, v);
    chk(busy_count == 3, "R2", "count after three", int'(busy_count), 3);
    complete(b);
    chk(busy_count == 2, "R2", "out of order retire", int'(busy_count), 2);
    complete(b);
    chk(busy_count == 2, "R10", "ghost completion ignored", int'(busy_count), 2);
    complete(a); complete(c);
    chk(busy_count == 0, "R2", "drained", int'(busy_count), 0);
  endtask

  task automatic t_exec();
    logic [3:0] a, e, p; bit u, v, r;
    issue(3'd0, 0, 0, a, u, v);
    probe_ready(3'd1, r);
    chk(!r, "R3", "exec sync waits for older", int'(r), 0);
    probe_ready(3'd5, r);
    chk(!r, "R3", "syscall waits for older", int'(r), 0);
    complete(a);
    issue(3'd1, 0, 0, e, u, v);
    probe_ready(3'd0, r);
    chk(!r, "R4", "younger blocked by exec sync", int'(r), 0);
    complete(e);
    probe_ready(3'd0, r);
    chk(r, "R4", "barrier released", int'(r), 1);
    issue(3'd0, 0, 0, p, u, v);
    complete(p);
  endtask

  task automatic t_msync();
    logic [3:0] a, s; bit u, v, r;
    issue(3'd0, 0, 0, a, u, v);
    issue(3'd3, 0, 0, s, u, v);
    chk(busy_count == 2, "R5", "sync issued with older pending", int'(busy_count), 2);
    probe_ready(3'd0, r);
    chk(!r, "R4", "younger blocked by sync", int'(r), 0);
    probe_cmp(s, r);
    chk(!r, "R5", "sync completion held", int'(r), 0);
    complete(a);
    probe_cmp(s, r);
    chk(r, "R5", "sync completion allowed when alone", int'(r), 1);
    complete(s);
    chk(busy_count == 0, "R5", "drained after sync", int'(busy_count), 0);
  endtask

  task automatic t_msrw();
    logic [3:0] t; bit u, v;
    issue(3'd2, 1, 0, t, u, v);
    complete(t);
    chk(arch_user == 1, "R6", "arch after state write", int'(arch_user), 1);
    chk(eff_user == 0, "R6", "eff kept after state write", int'(eff_user), 0);
    issue(3'd0, 0, 1, t, u, v);
    chk(u == 0 && v == 0, "R6", "old context, no violation", int'({u, v}), 0);
    complete(t);
    issue(3'd4, 0, 0, t, u, v);
    complete(t);
    chk(eff_user == 1, "R7", "isync refreshes eff", int'(eff_user), 1);
    issue(3'd0, 0, 1, t, u, v);
    chk(u == 1 && v == 1, "R9", "user context flags privileged", int'({u, v}), 3);
    complete(t);
    issue(3'd0, 0, 0, t, u, v);
    chk(u == 1 && v == 0, "R9", "unprivileged not flagged", int'({u, v}), 2);
    complete(t);
  endtask

  task automatic t_ctxchg();
    logic [3:0] t; bit u, v;
    issue(3'd5, 1, 0, t, u, v);
    complete(t);
    chk(arch_user == 0 && eff_user == 0, "R8", "syscall to supervisor",
        int'({arch_user, eff_user}), 0);
    issue(3'd6, 1, 0, t, u, v);
    complete(t);
    chk(arch_user == 1 && eff_user == 1, "R8", "rfi to user",
        int'({arch_user, eff_user}), 3);
    issue(3'd6, 0, 0, t, u, v);
    complete(t);
    chk(arch_user == 0 && eff_user == 0, "R8", "rfi to supervisor",
        int'({arch_user, eff_user}), 0);
  endtask

  task automatic t_fill();
    logic [3:0] tags [15]; bit u, v, r;
    for (int i = 0; i < 15; i++) issue(3'd0, 0, 0, tags[i], u, v);
    chk(busy_count == 15, "R2", "full count", int'(busy_count), 15);
    probe_ready(3'd0, r);
    chk(!r, "R2", "ready low at limit", int'(r), 0);
    for (int i = 0; i < 15; i++) complete(tags[i]);
    chk(busy_count == 0, "R2", "drained after fill", int'(busy_count), 0);
  endtask

  task automatic t_collide();
    logic [3:0] tags [15]; logic [3:0] x; bit u, v, r;
    for (int i = 0; i < 15; i++) issue(3'd0, 0, 0, tags[i], u, v);
    for (int i = 1; i < 15; i++) complete(tags[i]);
    issue(3'd0, 0, 0, x, u, v);
    chk(busy_count == 2, "R11", "count before collision", int'(busy_count), 2);
    probe_ready(3'd0, r);
    chk(!r, "R11", "ready low on busy next tag", int'(r), 0);
    complete(tags[0]);
    probe_ready(3'd0, r);
    chk(r, "R11", "ready back once tag frees", int'(r), 1);
    complete(x);
    chk(busy_count == 0, "R11", "drained", int'(busy_count), 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_exec();
    t_msync();
    t_msrw();
    t_ctxchg();
    t_fill();
    t_collide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule